// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog down-counter with a small synchronous register port. Software programs a timeout in ticks, releases a halt bit, and must then service the counter periodically by writing a fixed key to the reload register. The counter advances only on cycles where the tick-enable input is high. A tick is nominally 0.6 s, so N seconds maps to N*10/6 ticks; converting seconds to ticks is left to software.

When the count runs out for the first time, the block sets a first-stage status flag and reloads. Software is expected to notice that flag and clear it. If the count runs out again while the first-stage flag is still set, the block sets a second-stage flag and emits a one-cycle system reset pulse. An external no-reboot strap can suppress that pulse. The second-stage flag is still recorded when the pulse is blocked.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the block is halted (control reads 0x0800), the timeout reads 0x0004, the remaining count reads 0x0004, both status registers read 0 and the reset output is low.
- R2: The timer register (address 1) stores the timeout in bits 9:0. Bits 15:10 of a write are discarded and always read back as 0.
- R3: A timer write whose bits 9:0 hold a value below 4 is rejected, and the previous timeout is kept. A value of exactly 4 is accepted.
- R4: Writing exactly 0x0001 to the reload register (address 0) loads the remaining count from the current timeout. Any other value written there has no effect.
- R5: Reading the reload register returns the remaining count in bits 9:0, with the upper bits 0.
- R6: Control register (address 2) bit 11 is the halt bit. While it is 1 the count does not change on ticks. It reads back as written, and all other control bits read 0.
- R7: The count changes only on cycles with tick-enable high. A reload write in the same cycle as a tick takes priority over the decrement.
- R8: A tick that arrives while the count is 0 is an expiry. If status-1 bit 3 is clear, the expiry sets that bit and reloads the count from the timeout.
- R9: Writing a 1 to status-1 (address 3) bit 3 clears it. Writing a 0 there leaves it unchanged.
- R10: An expiry while status-1 bit 3 is set sets status-2 (address 4) bit 1, reloads the count, and drives the reset output high for exactly one cycle.
- R11: Writing a 1 to status-2 bit 1 clears it. Writing a 0 there leaves it unchanged.
- R12: While the no-reboot input is high, a second-stage expiry still sets status-2 bit 1 but produces no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en | input | 1 | Counter advances on cycles where this is high |
| no_reboot | input | 1 | Strap that blocks the reset pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume that one register access happens per cycle and that `addr` only carries the five defined codes during writes. They also rely on the timeout never falling below four ticks, which is what makes back-to-back reset pulses impossible. The stimulus drives each access for one full cycle, changing inputs only on the falling edge, and uses only defined addresses. Tick-enable is raised in bursts of known length so that every expiry lands on a predictable count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    A_RELOAD = 3'd0,
    A_TIMER  = 3'd1,
    A_CTRL   = 3'd2,
    A_STAT1  = 3'd3,
    A_STAT2  = 3'd4
  } wdt_addr_e;

  localparam int HALT_BIT   = 11;
  localparam int ST1_BIT    = 3;
  localparam int ST2_BIT    = 1;
  localparam int RELOAD_KEY = 1;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 10,
  parameter int MIN_TMO = 4,
  parameter int RST_TMO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  tmo_q,
  output logic              halt_q,
  output logic              reload_req
);
  logic [CNT_W-1:0] tmo_d;
  logic             halt_d;
  logic             tmo_we, ctrl_we;

  assign tmo_we  = wr_en && (addr == A_TIMER) &&
                   (wdata[CNT_W-1:0] >= CNT_W'(MIN_TMO));
  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign reload_req = wr_en && (addr == A_RELOAD) &&
                      (wdata == DATA_W'(RELOAD_KEY));

  always_comb begin
    tmo_d  = tmo_q;
    halt_d = halt_q;
    if (tmo_we)  tmo_d  = wdata[CNT_W-1:0];
    if (ctrl_we) halt_d = wdata[HALT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= CNT_W'(RST_TMO);
      halt_q <= 1'b1;
    end else begin
      tmo_q  <= tmo_d;
      halt_q <= halt_d;
    end
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W   = 10,
  parameter int RST_TMO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = step && at_zero && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load || expire) cnt_d = load_val;
    else if (step)      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RST_TMO);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_stage_ctrl.sv
module wdt_stage_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic no_reboot,
  input  logic clr1,
  input  logic clr2,
  output logic st1_q,
  output logic st2_q,
  output logic pulse_q
);
  logic st1_d, st2_d, pulse_d;
  logic second;

  assign second = expire && st1_q;

  always_comb begin
    st1_d   = st1_q;
    st2_d   = st2_q;
    pulse_d = 1'b0;
    if (clr1) st1_d = 1'b0;
    if (clr2) st2_d = 1'b0;
    if (expire && !st1_q) st1_d = 1'b1;
    if (second) begin
      st2_d   = 1'b1;
      pulse_d = !no_reboot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q   <= 1'b0;
      st2_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st1_q   <= st1_d;
      st2_q   <= st2_d;
      pulse_q <= pulse_d;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 10,
  parameter int MIN_TMO = 4,
  parameter int RST_TMO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              no_reboot,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_rst
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [CNT_W-1:0] tmo_q, cnt_q;
  logic             halt_q, reload_req, expire;
  logic             st1_q, st2_q, clr1, clr2;

  wdt_cfg_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_TMO(MIN_TMO), .RST_TMO(RST_TMO)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tmo_q(tmo_q), .halt_q(halt_q), .reload_req(reload_req)
  );

  wdt_down_counter #(.CNT_W(CNT_W), .RST_TMO(RST_TMO)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(reload_req), .load_val(tmo_q),
    .step(tick_en && !halt_q), .cnt_q(cnt_q), .expire(expire)
  );

  assign clr1 = wr_en && (addr == A_STAT1) && wdata[ST1_BIT];
  assign clr2 = wr_en && (addr == A_STAT2) && wdata[ST2_BIT];

  wdt_stage_ctrl u_stage (
    .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
    .clr1(clr1), .clr2(clr2), .st1_q(st1_q), .st2_q(st2_q),
    .pulse_q(sys_rst)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_RELOAD: rdata = {{PAD_W{1'b0}}, cnt_q};
      A_TIMER:  rdata = {{PAD_W{1'b0}}, tmo_q};
      A_CTRL:   rdata[HALT_BIT] = halt_q;
      A_STAT1:  rdata[ST1_BIT]  = st1_q;
      A_STAT2:  rdata[ST2_BIT]  = st2_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 10,
  parameter int MIN_TMO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              no_reboot,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              sys_rst,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  tmo,
  input logic              halt,
  input logic              st1,
  input logic              st2
);
  logic kick;
  assign kick = wr_en && (addr == 3'd0) && (wdata == DATA_W'(1));

  AST_TMO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo >= CNT_W'(MIN_TMO)); // R3
  AST_KICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == $past(tmo))); // R4
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !kick) |=> $stable(cnt)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !kick) |=> $stable(cnt)); // R7
  AST_ST2_AFTER_ST1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st2) |-> $past(st1)); // R10
  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> st2); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst); // R10
  AST_STRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> !$past(no_reboot)); // R12
endmodule

bind wdt_two_stage wdt_two_stage_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_TMO(MIN_TMO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .no_reboot(no_reboot),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .sys_rst(sys_rst),
  .cnt(cnt_q), .tmo(tmo_q), .halt(halt_q), .st1(st1_q), .st2(st2_q)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        no_reboot = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        sys_rst;

  int n_chk = 0, n_bad = 0;
  int pulses = 0, run = 0, maxrun = 0;

  always #2.5 clk = ~clk;

  wdt_two_stage u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .no_reboot(no_reboot),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .sys_rst(sys_rst)
  );

  always @(negedge clk) begin
    if (rst_n && sys_rst) begin
      pulses = pulses + 1;
      run = run + 1;
      if (run > maxrun) maxrun = run;
    end else run = 0;
  end

  // ops: 0 write, 1 read-compare, 2 tick bursts, 3 idle cycles
  // fields: op[44:43] addr[42:40] data[39:24] exp[23:8] req[7:0]
  localparam int NV = 36;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {2'd1, 3'd1, 16'h0000, 16'h0004, 8'd1},  // R1 timeout
    {2'd1, 3'd2, 16'h0000, 16'h0800, 8'd1},  // R1 halted
    {2'd1, 3'd0, 16'h0000, 16'h0004, 8'd1},  // R1 count
    {2'd1, 3'd3, 16'h0000, 16'h0000, 8'd1},  // R1 stat1
    {2'd1, 3'd4, 16'h0000, 16'h0000, 8'd1},  // R1 stat2
    {2'd0, 3'd1, 16'hFC0A, 16'h0000, 8'd2},
    {2'd1, 3'd1, 16'h0000, 16'h000A, 8'd2},  // R2 upper bits dropped
    {2'd0, 3'd1, 16'h0003, 16'h0000, 8'd3},
    {2'd1, 3'd1, 16'h0000, 16'h000A, 8'd3},  // R3 reject 3
    {2'd0, 3'd1, 16'h0000, 16'h0000, 8'd3},
    {2'd1, 3'd1, 16'h0000, 16'h000A, 8'd3},  // R3 reject 0
    {2'd0, 3'd1, 16'h0004, 16'h0000, 8'd3},
    {2'd1, 3'd1, 16'h0000, 16'h0004, 8'd3},  // R3 accept 4
    {2'd0, 3'd1, 16'h03FF, 16'h0000, 8'd2},
    {2'd1, 3'd1, 16'h0000, 16'h03FF, 8'd2},  // R2 max
    {2'd2, 3'd0, 16'd3,    16'h0000, 8'd6},
    {2'd1, 3'd0, 16'h0000, 16'h0004, 8'd6},  // R6 frozen
    {2'd0, 3'd0, 16'h0001, 16'h0000, 8'd4},
    {2'd1, 3'd0, 16'h0000, 16'h03FF, 8'd4},  // R4 kick
    {2'd0, 3'd1, 16'h0008, 16'h0000, 8'd4},
    {2'd0, 3'd0, 16'h0002, 16'h0000, 8'd4},
    {2'd1, 3'd0, 16'h0000, 16'h03FF, 8'd4},  // R4 wrong key
    {2'd0, 3'd0, 16'h0001, 16'h0000, 8'd4},
    {2'd1, 3'd0, 16'h0000, 16'h0008, 8'd4},  // R4 kick
    {2'd0, 3'd2, 16'hFFFF, 16'h0000, 8'd6},
    {2'd1, 3'd2, 16'h0000, 16'h0800, 8'd6},  // R6 only bit 11
    {2'd0, 3'd2, 16'h0000, 16'h0000, 8'd6},
    {2'd1, 3'd2, 16'h0000, 16'h0000, 8'd6},  // R6 run
    {2'd3, 3'd0, 16'd3,    16'h0000, 8'd7},
    {2'd1, 3'd0, 16'h0000, 16'h0008, 8'd7},  // R7 no tick no change
    {2'd2, 3'd0, 16'd3,    16'h0000, 8'd5},
    {2'd1, 3'd0, 16'h0000, 16'h0005, 8'd5},  // R5 count 5
    {2'd2, 3'd0, 16'd6,    16'h0000, 8'd8},
    {2'd1, 3'd0, 16'h0000, 16'h0008, 8'd8},  // R8 reloaded
    {2'd1, 3'd3, 16'h0000, 16'h0008, 8'd8},  // R8 flag
    {2'd0, 3'd3, 16'h0000, 16'h0000, 8'd9}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 16'h0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input int req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {15'h0, sys_rst}, 16'h0);  // R1 output low

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][44:43])
        2'd0: wr(VEC[i][42:40], VEC[i][39:24]);
        2'd1: rd(VEC[i][42:40], VEC[i][23:8], int'(VEC[i][7:0]));
        2'd2: ticks(int'(VEC[i][39:24]));
        default: repeat (int'(VEC[i][39:24])) @(negedge clk);
      endcase
    end
    rd(3'd3, 16'h0008, 9);            // R9 write of 0 kept flag
    wr(3'd3, 16'h0008);
    rd(3'd3, 16'h0000, 9);            // R9 cleared

    ticks(2);
    rd(3'd0, 16'h0006, 5);            // R5
    tick_en = 1'b1;                   // R7 kick beats decrement
    wr(3'd0, 16'h0001);
    tick_en = 1'b0;
    rd(3'd0, 16'h0008, 7);

    ticks(9);                         // first stage again
    rd(3'd3, 16'h0008, 8);
    rd(3'd4, 16'h0000, 8);
    check(8, 16'(pulses), 16'd0);     // R8 no pulse on first stage
    ticks(9);                         // second stage
    rd(3'd4, 16'h0002, 10);           // R10 flag
    rd(3'd3, 16'h0008, 10);
    check(10, 16'(pulses), 16'd1);    // R10 one pulse
    check(10, 16'(maxrun), 16'd1);    // R10 one cycle wide
    wr(3'd4, 16'h0000);
    rd(3'd4, 16'h0002, 11);           // R11 write 0 ignored
    wr(3'd4, 16'h0002);
    rd(3'd4, 16'h0000, 11);           // R11 cleared

    no_reboot = 1'b1;
    p0 = pulses;
    ticks(9);
    rd(3'd4, 16'h0002, 12);           // R12 flag still set
    check(12, 16'(pulses - p0), 16'd0); // R12 pulse blocked
    no_reboot = 1'b0;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, 16'h0004, 1);            // R1 after mid-run reset
    rd(3'd2, 16'h0800, 1);
    rd(3'd3, 16'h0000, 1);
    rd(3'd4, 16'h0000, 1);
    finish_run();
  end
endmodule